// File: doc/BRIEF.md
# Per-Slice Vector Byte Slide Unit

This unit computes the result of an element-slide operation on a 128-bit vector register. The register is split into equal, independent slices whose size follows a 2-bit format code. Inside every slice, the bytes of the source operand and the bytes of the current destination operand are joined into a byte array twice the slice width. The source bytes sit in the lower half of that array and the destination bytes in the upper half. The slice result is the slice-wide window that starts at the byte offset given by the immediate. A second operation, the move, copies the source to the result unchanged.

The unit is one pipeline stage. A request is accepted on any clock edge where `in_valid` is high. Its result, with a fault flag, appears one cycle later. Instruction decode and register-file access are done by the surrounding datapath. A small state machine marks what the output register holds:

- `RS_IDLE`: no result.
- `RS_DONE`: a good result.
- `RS_FAULT`: a rejected slide.

On every edge the next state depends only on the incoming request:

- An accepted move, or a slide whose offset is in range, goes to `RS_DONE`.
- A slide whose offset is out of range goes to `RS_FAULT`.
- No request goes to `RS_IDLE`.

These transitions apply from every state.

Top module: `vslide_unit`

## Requirements
- R1: After reset `out_valid`, `out_err` and `out_vec` are 0. `out_valid` is high in exactly the cycle after each edge that samples `in_valid` high, and low otherwise.
- R2: The format code `in_fmt` selects the slice size s: 0 gives one 16-byte slice, 1 gives two 8-byte slices, 2 gives four 4-byte slices, 3 gives eight 2-byte slices. The lane count of the format equals s.
- R3: For a slide (`in_op` = 0) with offset n = `in_imm` below s, output byte i of slice k is taken from the joined array at position i+n. Positions below s are source byte s*k+i+n; positions from s upward are destination byte s*k+i+n-s. Byte 0 is bits 7:0, and slice k starts at byte s*k.
- R4: Every slice is computed only from its own bytes of the pre-operation source and destination. A value in one slice never reaches another slice.
- R5: A move (`in_op` = 1) returns `src_vec` unchanged with `out_err` low, whatever `in_fmt` and `in_imm` are.
- R6: A slide with n greater than or equal to s raises `out_err` and returns `dst_vec` unchanged.
- R7: A slide with n = 0 returns the source. A slide with n = s-1 puts the top source byte of each slice in the slice's lowest byte, followed by the slice's low destination bytes.
- R8: Requests may arrive on consecutive cycles. Each request yields its own result in order, with no lost or repeated cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 1 | 0 = slide, 1 = move |
| in_fmt | input | 2 | Slice format code |
| in_imm | input | IMM_W | Byte offset n |
| src_vec | input | NB*8 | Source operand |
| dst_vec | input | NB*8 | Current destination operand |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Offset out of range, result is the old destination |
| out_vec | output | NB*8 | New destination value |

## Verification
The checker watches several properties on every cycle:

- The result register stays quiet when no request arrives.
- A move is an exact copy of the source.
- A zero offset returns the source.
- Every out-of-range slide raises the fault flag and returns the old destination.
- In-range slides never fault.

The precise byte placement inside each slice cannot be stated as a compact property. This covers the slice independence for each format and the n = s-1 edge. Ordered delivery under back-to-back traffic also needs the bench, which compares every result against a reference model and against hand-worked constant vectors.

// File: rtl/vslide_pkg.sv
package vslide_pkg;
    typedef enum logic [1:0] {
        FMT_B8  = 2'd0,
        FMT_B4  = 2'd1,
        FMT_B2  = 2'd2,
        FMT_B1  = 2'd3
    } vfmt_e;

    typedef enum logic {
        OP_SLIDE = 1'b0,
        OP_MOVE  = 1'b1
    } vop_e;

    typedef enum logic [1:0] {
        RS_IDLE  = 2'd0,
        RS_DONE  = 2'd1,
        RS_FAULT = 2'd2
    } rstate_e;

    localparam int NUM_FMT = 4;
endpackage

// File: rtl/vslide_window.sv
module vslide_window #(
    parameter int NB    = 16,
    parameter int IMM_W = 6
) (
    input  logic [NB*8-1:0]  src,
    input  logic [NB*8-1:0]  dst,
    input  logic [1:0]       fmt,
    input  logic [IMM_W-1:0] imm,
    output logic [NB*8-1:0]  win
);
    import vslide_pkg::*;

    logic [NUM_FMT-1:0][NB*8-1:0] cand;

    generate
        for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
            localparam int S = NB >> f;
            localparam int K = NB / S;
            logic [NB*8-1:0] part;
            always_comb begin
                part = '0;
                for (int k = 0; k < K; k++) begin
                    for (int i = 0; i < S; i++) begin
                        int j;
                        j = i + int'(imm);
                        if (j < S)
                            part[(k*S+i)*8 +: 8] = src[(k*S+j)*8 +: 8];
                        else if (j < 2*S)
                            part[(k*S+i)*8 +: 8] = dst[(k*S+j-S)*8 +: 8];
                    end
                end
            end
            assign cand[f] = part;
        end
    endgenerate

    assign win = cand[fmt];
endmodule

// File: rtl/vslide_limit.sv
module vslide_limit #(
    parameter int NB    = 16,
    parameter int IMM_W = 6
) (
    input  logic [1:0]       fmt,
    input  logic [IMM_W-1:0] imm,
    output logic             in_range
);
    always_comb begin
        int lanes;
        lanes    = NB >> fmt;
        in_range = (int'(imm) < lanes);
    end
endmodule

// File: rtl/vslide_unit.sv
module vslide_unit #(
    parameter int NB    = 16,
    parameter int IMM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [1:0]       in_fmt,
    input  logic [IMM_W-1:0] in_imm,
    input  logic [NB*8-1:0]  src_vec,
    input  logic [NB*8-1:0]  dst_vec,
    output logic             out_valid,
    output logic             out_err,
    output logic [NB*8-1:0]  out_vec
);
    import vslide_pkg::*;

    localparam int VW = NB * 8;

    rstate_e         state_q, state_d;
    logic [VW-1:0]   win;
    logic            in_range;
    logic            accept_ok;
    logic [VW-1:0]   res_q;

    vslide_window #(.NB(NB), .IMM_W(IMM_W)) u_window (
        .src (src_vec),
        .dst (dst_vec),
        .fmt (in_fmt),
        .imm (in_imm),
        .win (win)
    );

    vslide_limit #(.NB(NB), .IMM_W(IMM_W)) u_limit (
        .fmt      (in_fmt),
        .imm      (in_imm),
        .in_range (in_range)
    );

    assign accept_ok = (vop_e'(in_op) == OP_MOVE) || in_range;

    // next-state logic
    always_comb begin
        state_d = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_DONE, RS_FAULT: begin
                if (in_valid)
                    state_d = accept_ok ? RS_DONE : RS_FAULT;
                else
                    state_d = RS_IDLE;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (in_valid) begin
            if (vop_e'(in_op) == OP_MOVE) res_q <= src_vec;
            else if (in_range)            res_q <= win;
            else                          res_q <= dst_vec;
        end
    end

    // output decode
    always_comb begin
        out_vec = res_q;
        unique case (state_q)
            RS_DONE:  begin out_valid = 1'b1; out_err = 1'b0; end
            RS_FAULT: begin out_valid = 1'b1; out_err = 1'b1; end
            default:  begin out_valid = 1'b0; out_err = 1'b0; end
        endcase
    end
endmodule

// File: rtl/vslide_unit_chk.sv
module vslide_unit_chk #(
    parameter int NB    = 16,
    parameter int IMM_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_op,
    input logic [1:0]       in_fmt,
    input logic [IMM_W-1:0] in_imm,
    input logic [NB*8-1:0]  src_vec,
    input logic [NB*8-1:0]  dst_vec,
    input logic             out_valid,
    input logic             out_err,
    input logic [NB*8-1:0]  out_vec
);
    logic bad_off;
    always_comb bad_off = (int'(in_imm) >= (NB >> in_fmt));

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_err)); // R1

    AST_MOVE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op) |=> (out_valid && !out_err && out_vec == $past(src_vec))); // R5

    AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && bad_off) |=> (out_valid && out_err && out_vec == $past(dst_vec))); // R6

    AST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && in_imm == '0) |=> (out_valid && !out_err && out_vec == $past(src_vec))); // R7

    AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op && !bad_off) |=> (out_valid && !out_err)); // R3
endmodule

bind vslide_unit vslide_unit_chk #(.NB(NB), .IMM_W(IMM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_fmt    (in_fmt),
    .in_imm    (in_imm),
    .src_vec   (src_vec),
    .dst_vec   (dst_vec),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_vec   (out_vec)
);

// File: tb/vslide_unit_bench.sv
`timescale 1ns/1ps
module vslide_unit_bench;
    localparam int NB = 16;
    localparam int IMM_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_op = 1'b0;
    logic [1:0]       in_fmt = 2'd0;
    logic [IMM_W-1:0] in_imm = '0;
    logic [127:0]     src_vec = '0;
    logic [127:0]     dst_vec = '0;
    logic             out_valid;
    logic             out_err;
    logic [127:0]     out_vec;

    int checks = 0;
    int errors = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    typedef struct {
        logic         err;
        logic [127:0] vec;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    vslide_unit #(.NB(NB), .IMM_W(IMM_W)) u_vslide_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_fmt (in_fmt), .in_imm (in_imm), .src_vec (src_vec), .dst_vec (dst_vec),
        .out_valid (out_valid), .out_err (out_err), .out_vec (out_vec)
    );

    // reference model written from R2, R3, R5, R6
    function automatic logic [127:0] model(input logic op, input logic [1:0] fmt,
                                           input int n, input logic [127:0] s,
                                           input logic [127:0] d, output logic err);
        logic [127:0] r;
        int sz;
        err = 1'b0;
        if (op) return s;
        sz = 16 >> fmt;
        if (n >= sz) begin err = 1'b1; return d; end
        r = '0;
        for (int k = 0; k < 16 / sz; k++)
            for (int i = 0; i < sz; i++) begin
                int p;
                p = i + n;
                r[(k*sz+i)*8 +: 8] = (p < sz) ? s[(k*sz+p)*8 +: 8] : d[(k*sz+p-sz)*8 +: 8];
            end
        return r;
    endfunction

    task automatic drive(input logic op, input logic [1:0] fmt, input int n,
                         input logic [127:0] s, input logic [127:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_fmt = fmt; in_imm = IMM_W'(n);
        src_vec = s; dst_vec = d;
        e.vec = model(op, fmt, n, s, d, e.err);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive_fixed(input logic [1:0] fmt, input int n, input logic [127:0] s,
                               input logic [127:0] d, input logic [127:0] want, input string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_op = 1'b0; in_fmt = fmt; in_imm = IMM_W'(n);
        src_vec = s; dst_vec = d;
        e.vec = want; e.err = 1'b0; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic quiet();
        @(negedge clk);
        in_valid = 1'b0;
        in_op = 1'b1; in_fmt = 2'd3; in_imm = '1; src_vec = '1; dst_vec = '1;
    endtask

    function automatic logic [127:0] rvec();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                checks++;
                if (sb.size() > 0) begin
                    exp_t e;
                    e = sb.pop_front();
                    if (!(out_valid === 1'b1 && out_err === e.err && out_vec === e.vec)) begin
                        errors++;
                        $display("FAIL %s: actual valid=%0b err=%0b vec=%h expected valid=1 err=%0b vec=%h",
                                 e.tag, out_valid, out_err, out_vec, e.err, e.vec);
                    end
                end else if (out_valid !== 1'b0 || out_err !== 1'b0) begin
                    errors++;
                    $display("FAIL R1 idle: actual valid=%0b err=%0b expected valid=0 err=0",
                             out_valid, out_err);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] inc_s, inc_d;
        for (int b = 0; b < 16; b++) begin
            inc_s[b*8 +: 8] = 8'(b);
            inc_d[b*8 +: 8] = 8'(16 + b);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_err !== 1'b0 || out_vec !== '0) begin
            errors++;
            $display("FAIL R1 reset: actual valid=%0b err=%0b vec=%h expected 0 0 0",
                     out_valid, out_err, out_vec);
        end
        mon_on = 1'b1;

        // R3 whole-register slide, hand-worked
        drive_fixed(2'd0, 1, inc_s, inc_d, 128'h100F0E0D_0C0B0A09_08070605_04030201, "R3 byte n=1");
        quiet();
        // R4 / R2 word slices independent, hand-worked
        drive_fixed(2'd2, 1, inc_s, inc_d, 128'h1C0F0E0D_180B0A09_14070605_10030201, "R4 word n=1");
        quiet();
        // R7 top offset per format
        drive(1'b0, 2'd0, 15, rvec(), rvec(), "R7 byte n=15");
        drive(1'b0, 2'd1, 7, rvec(), rvec(), "R7 half n=7");
        drive(1'b0, 2'd2, 3, rvec(), rvec(), "R7 word n=3");
        drive(1'b0, 2'd3, 1, rvec(), rvec(), "R7 dword n=1");
        // R7 zero offset per format
        for (int f = 0; f < 4; f++) drive(1'b0, 2'(f), 0, rvec(), rvec(), "R7 n=0");
        quiet();
        // R5 move ignores fmt and imm
        drive(1'b1, 2'd3, 63, rvec(), rvec(), "R5 move");
        drive(1'b1, 2'd0, 5, rvec(), rvec(), "R5 move");
        quiet();
        // R6 out-of-range per format
        drive(1'b0, 2'd0, 16, rvec(), rvec(), "R6 byte n=16");
        drive(1'b0, 2'd1, 8, rvec(), rvec(), "R6 half n=8");
        drive(1'b0, 2'd2, 4, rvec(), rvec(), "R6 word n=4");
        drive(1'b0, 2'd3, 2, rvec(), rvec(), "R6 dword n=2");
        quiet();
        // R2 mid offsets, R8 back-to-back burst
        drive(1'b0, 2'd1, 3, inc_s, inc_d, "R2 half n=3");
        drive(1'b0, 2'd2, 2, inc_s, inc_d, "R2 word n=2");
        for (int t = 0; t < 80; t++) begin
            logic op;
            logic [1:0] f;
            int n;
            op = ($urandom % 8) == 0;
            f = 2'($urandom % 4);
            n = (t % 7 == 0) ? int'($urandom % 64) : int'($urandom % (16 >> f));
            drive(op, f, n, rvec(), rvec(), "R8 burst");
        end
        quiet();
        repeat (4) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R8 pending: actual=%0d expected=0", sb.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule